// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This unit is the status and interrupt half of an SPI controller. It buffers outgoing bytes in a 32-byte transmit FIFO and incoming bytes in a 32-byte receive FIFO. Both FIFOs sit between a 32-bit register port and the serial shift engine, which moves one byte per cycle. Software reaches both FIFOs, an event word, an interrupt mask and a threshold register through the register port. The shift engine pulls transmit bytes and pushes received bytes through a simple byte interface.

The event word shows both FIFO occupancy counts live. It also holds two sticky flags. One flags that the receive FIFO holds more bytes than a programmed threshold. The other flags that the transmit FIFO has more free space than a second programmed threshold. Software clears the flags by writing ones to them. A single interrupt line is raised while any flag is set and its mask bit is enabled.

Register addresses on `regAddr`: 0 = threshold register, 1 = event word, 2 = mask, 3 = transmit data, 4 = receive data. Read data appears on `regRdata` one cycle after a read strobe. A read of any other address returns zero.

Top module: `spiFifoEvtUnit`

## Requirements
- R1: The event word carries the receive byte count in bits 29:24 and the transmit byte count in bits 21:16. Bit 9 is the receive event, bit 8 is the transmit event, and every other bit reads zero.
- R2: A 32-bit write to the transmit-data address queues four bytes, bits 31:24 first. The engine sees them in that order on `txByte`, and `txHasData` is high while the FIFO is non-empty. A `txPop` while the FIFO is empty has no effect.
- R3: A transmit-data write is dropped entirely when fewer than four bytes are free.
- R4: A word read of the receive-data address pops up to four bytes, the oldest in bits 31:24. With fewer than four bytes present, it returns those bytes in the upper lanes and zeros below. With the FIFO empty it returns zero.
- R5: A byte read of the receive-data address (`regByte` = 1) pops one byte into bits 7:0, with zeros above. It returns zero when the FIFO is empty.
- R6: An `rxPush` arriving while the receive FIFO holds 32 bytes is discarded.
- R7: The receive event sets on the clock edge after the receive count exceeds the receive threshold. It stays set until it is cleared.
- R8: The transmit event sets on the clock edge after the free transmit space (32 minus the count) exceeds the transmit threshold. It stays set until it is cleared.
- R9: Writing the event word clears each event bit written as 1. Bits written as 0 are unchanged. If a bit's set condition holds in the same cycle as the clear, the set wins.
- R10: The mask register enables the receive event at bit 9 and the transmit event at bit 8, and reads back those bits. `irq` is high exactly when some event bit and its mask bit are both set.
- R11: The threshold register holds the transmit threshold in bits 15:8 and the receive threshold in bits 7:0. It resets to 4 and 3 and reads back as written.
- R12: The count fields of the event word are read-only. Writing the event word, even with all ones, leaves both counts unchanged.
- R13: After reset, both FIFOs are empty, both event bits and both mask bits are clear, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register select |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regByte | input | 1 | Byte-size access for receive-data reads |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid the cycle after `regRd` |
| txPop | input | 1 | Engine takes the head transmit byte |
| txByte | output | 8 | Head transmit byte |
| txHasData | output | 1 | Transmit FIFO non-empty |
| rxPush | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest states to reach from the ports are the edges of the receive FIFO. These include a full FIFO that must drop a further byte, and a partly filled FIFO that a word read drains with only one to three bytes present. Another is an event clear that lands in the same cycle its set condition still holds. Directed sequences push 33 bytes, read across the partial boundary, and issue an all-ones clear with the receive count above threshold. A long seeded random phase then mixes engine traffic, word and byte reads, and threshold rewrites to sweep the counts back and forth across both thresholds.

// File: rtl/spiEvtPkg.sv
package spiEvtPkg;
  localparam int LANES = 4;       // bytes per register word
  localparam int CNT_FIELD = 6;   // width of each count field in the event word

  typedef enum logic [2:0] {
    ADDR_MODE   = 3'd0,
    ADDR_EVENT  = 3'd1,
    ADDR_MASK   = 3'd2,
    ADDR_TXDATA = 3'd3,
    ADDR_RXDATA = 3'd4
  } regAddrT;

  // control-to-datapath strobes
  typedef struct packed {
    logic [2:0] txPush;  // bytes pushed into transmit FIFO
    logic       txPop;   // engine pop
    logic       rxPush;  // engine push
    logic [2:0] rxPop;   // bytes popped by a register read
  } fifoStrobeT;
endpackage

// File: rtl/byteFifo.sv
module byteFifo #(
  parameter int DEPTH = 32,
  parameter int AW = $clog2(DEPTH),
  parameter int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    pushCnt,
  input  logic [31:0]   pushWord,
  input  logic [2:0]    popCnt,
  output logic [CW-1:0] count,
  output logic [31:0]   headWord
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < pushCnt) mem[wrPtr + AW'(i)] <= pushWord[31-8*i -: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushCnt);
      rdPtr <= rdPtr + AW'(popCnt);
      count <= count + CW'(pushCnt) - CW'(popCnt);
    end
  end

  for (genvar g = 0; g < 4; g++) begin : gHead
    assign headWord[31-8*g -: 8] = mem[rdPtr + AW'(g)];
  end

  // R6, R3: the control never lets the FIFO exceed its depth
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(count) + int'(pushCnt)) <= (DEPTH + int'(popCnt)));
  // R4: never pop more bytes than are present
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(popCnt) <= int'(count));
endmodule

// File: rtl/spiEvtDatapath.sv
module spiEvtDatapath import spiEvtPkg::*; #(
  parameter int DEPTH = 32,
  parameter int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobeT    strobe,
  input  logic [31:0]   txWord,
  input  logic [7:0]    rxByte,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic [31:0]   rxHead,
  output logic [7:0]    txByte,
  output logic          txHasData
);
  logic [31:0] txHead;

  byteFifo #(.DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(rstN),
    .pushCnt(strobe.txPush), .pushWord(txWord),
    .popCnt({2'b00, strobe.txPop}),
    .count(txCount), .headWord(txHead)
  );

  byteFifo #(.DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN),
    .pushCnt({2'b00, strobe.rxPush}), .pushWord({rxByte, 24'h0}),
    .popCnt(strobe.rxPop),
    .count(rxCount), .headWord(rxHead)
  );

  assign txByte    = txHead[31:24];
  assign txHasData = (txCount != '0);
endmodule

// File: rtl/spiEvtCtrl.sv
module spiEvtCtrl import spiEvtPkg::*; #(
  parameter int DEPTH = 32,
  parameter int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    regAddr,
  input  logic          regWr,
  input  logic          regRd,
  input  logic          regByte,
  input  logic [31:0]   regWdata,
  input  logic          txEngPop,
  input  logic          rxEngPush,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic [31:0]   rxHead,
  output fifoStrobeT    strobe,
  output logic [31:0]   regRdata,
  output logic          irq
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] LANES_C = CW'(LANES);

  logic [7:0]    txThr, rxThr;
  logic [1:0]    maskBits, evtBits;   // [1] receive, [0] transmit
  logic [CW-1:0] txFree;
  logic          txWordWr, rxRead, evtWr;
  logic [2:0]    rxTake;
  logic [1:0]    evtSet, evtClr;
  logic [31:0]   rxWordData, rdMux;

  assign txFree   = DEPTH_C - txCount;
  assign txWordWr = regWr && (regAddr == ADDR_TXDATA) && (txFree >= LANES_C);
  assign rxRead   = regRd && (regAddr == ADDR_RXDATA);
  assign evtWr    = regWr && (regAddr == ADDR_EVENT);

  always_comb begin
    if (regByte)               rxTake = (rxCount != '0) ? 3'd1 : 3'd0;
    else if (rxCount >= LANES_C) rxTake = 3'd4;
    else                       rxTake = rxCount[2:0];
  end

  always_comb begin
    strobe.txPush = txWordWr ? 3'd4 : 3'd0;
    strobe.txPop  = txEngPop && (txCount != '0);
    strobe.rxPush = rxEngPush && (rxCount != DEPTH_C);
    strobe.rxPop  = rxRead ? rxTake : 3'd0;
  end

  for (genvar g = 0; g < LANES; g++) begin : gRxLane
    assign rxWordData[31-8*g -: 8] = (CW'(g) < rxCount) ? rxHead[31-8*g -: 8] : 8'h00;
  end

  always_comb begin
    case (regAddr)
      ADDR_MODE:   rdMux = {16'h0, txThr, rxThr};
      ADDR_EVENT:  rdMux = {2'b00, CNT_FIELD'(rxCount), 2'b00, CNT_FIELD'(txCount),
                            6'h0, evtBits, 8'h00};
      ADDR_MASK:   rdMux = {22'h0, maskBits, 8'h00};
      ADDR_RXDATA: rdMux = regByte ? {24'h0, rxWordData[31:24]} : rxWordData;
      default:     rdMux = 32'h0;
    endcase
  end

  assign evtSet[1] = {{(8-CW+1){1'b0}}, rxCount} > {1'b0, rxThr};
  assign evtSet[0] = {{(8-CW+1){1'b0}}, txFree} > {1'b0, txThr};
  assign evtClr    = evtWr ? regWdata[9:8] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txThr    <= 8'd4;
      rxThr    <= 8'd3;
      maskBits <= 2'b00;
      evtBits  <= 2'b00;
      regRdata <= 32'h0;
    end else begin
      if (regRd) regRdata <= rdMux;
      if (regWr && regAddr == ADDR_MODE) {txThr, rxThr} <= regWdata[15:0];
      if (regWr && regAddr == ADDR_MASK) maskBits <= regWdata[9:8];
      evtBits <= (evtBits & ~evtClr) | evtSet;
    end
  end

  assign irq = |(evtBits & maskBits);

  // R7: receive count above threshold latches the receive event next edge
  assert_rx_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    ({2'b00, rxCount} > {1'b0, rxThr}) |=> evtBits[1]);
  // R8: free space above threshold latches the transmit event next edge
  assert_tx_event_R8: assert property (@(posedge clk) disable iff (!rstN)
    ({2'b00, txFree} > {1'b0, txThr}) |=> evtBits[0]);
  // R9: an event bit stays set unless a one is written to it
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (evtBits[1] && !(evtWr && regWdata[9])) |=> evtBits[1]);
  // R3: a rejected word write leaves the transmit count alone
  assert_tx_reject_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_TXDATA && txFree < LANES_C && !txEngPop) |=> $stable(txCount));
endmodule

// File: rtl/spiFifoEvtUnit.sv
module spiFifoEvtUnit import spiEvtPkg::*; #(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic        regByte,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        txPop,
  output logic [7:0]  txByte,
  output logic        txHasData,
  input  logic        rxPush,
  input  logic [7:0]  rxByte,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  fifoStrobeT    strobe;
  logic [CW-1:0] txCount, rxCount;
  logic [31:0]   rxHead;

  spiEvtCtrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regByte(regByte), .regWdata(regWdata), .txEngPop(txPop), .rxEngPush(rxPush),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .strobe(strobe), .regRdata(regRdata), .irq(irq)
  );

  spiEvtDatapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWord(regWdata), .rxByte(rxByte),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .txByte(txByte), .txHasData(txHasData)
  );
endmodule

// File: tb/tb_spiFifoEvtUnit.sv
module tb_spiFifoEvtUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0, regByte = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        txPop = 1'b0, rxPush = 1'b0;
  logic [7:0]  rxByte = '0;
  logic [7:0]  txByte;
  logic        txHasData, irq;

  spiFifoEvtUnit dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regByte(regByte), .regWdata(regWdata), .regRdata(regRdata),
    .txPop(txPop), .txByte(txByte), .txHasData(txHasData),
    .rxPush(rxPush), .rxByte(rxByte), .irq(irq)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0, nErr = 0;
  logic [7:0] txQ[$], rxQ[$];
  logic [7:0] mTx = 8'd4, mRx = 8'd3;
  logic       mEvRx = 1'b0, mEvTx = 1'b0, mMkRx = 1'b0, mMkTx = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] evtWord(int rc, int tc, logic er, logic et);
    return {2'b00, 6'(rc), 2'b00, 6'(tc), 6'h0, er, et, 8'h00};
  endfunction

  function automatic logic [31:0] rxWord(int rc);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) if (i < rc) w[31-8*i -: 8] = rxQ[i];
    return w;
  endfunction

  // one clock cycle; called and returns at a negedge
  task automatic step(input logic [2:0] a, input logic w, input logic r, input logic b,
                      input logic [31:0] d, input logic ep, input logic eh, input logic [7:0] eb);
    int tc = txQ.size();
    int rc = rxQ.size();
    logic [31:0] expRd = '0;
    string rtag = "R1";
    logic setRx, setTx;
    regAddr = a; regWr = w; regRd = r; regByte = b; regWdata = d;
    txPop = ep; rxPush = eh; rxByte = eb;
    #1;
    chk("R2", {31'h0, txHasData}, {31'h0, tc > 0});
    if (ep && tc > 0) chk("R2", {24'h0, txByte}, {24'h0, txQ[0]});
    case (a)
      3'd0: begin expRd = {16'h0, mTx, mRx}; rtag = "R11"; end
      3'd1: begin expRd = evtWord(rc, tc, mEvRx, mEvTx); rtag = "R1"; end
      3'd2: begin expRd = {22'h0, mMkRx, mMkTx, 8'h00}; rtag = "R10"; end
      3'd4: begin
        expRd = b ? {24'h0, (rc > 0) ? rxQ[0] : 8'h00} : rxWord(rc);
        rtag = b ? "R5" : "R4";
      end
      default: expRd = '0;
    endcase
    setRx = rc > int'(mRx);
    setTx = (32 - tc) > int'(mTx);
    if (w && a == 3'd1) begin
      if (d[9]) mEvRx = 1'b0;
      if (d[8]) mEvTx = 1'b0;
    end
    mEvRx = mEvRx | setRx;
    mEvTx = mEvTx | setTx;
    if (w && a == 3'd0) begin mTx = d[15:8]; mRx = d[7:0]; end
    if (w && a == 3'd2) begin mMkRx = d[9]; mMkTx = d[8]; end
    if (ep && tc > 0) void'(txQ.pop_front());
    if (w && a == 3'd3 && (32 - tc) >= 4)
      for (int i = 0; i < 4; i++) txQ.push_back(d[31-8*i -: 8]);
    if (r && a == 3'd4) begin
      int n = b ? ((rc > 0) ? 1 : 0) : ((rc >= 4) ? 4 : rc);
      for (int i = 0; i < n; i++) void'(rxQ.pop_front());
    end
    if (eh && rc < 32) rxQ.push_back(eb);
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0; regRd = 1'b0; txPop = 1'b0; rxPush = 1'b0;
    if (r) chk(rtag, regRdata, expRd);
    chk("R10", {31'h0, irq}, {31'h0, (mEvRx & mMkRx) | (mEvTx & mMkTx)});
  endtask

  task automatic idle();          step(3'd0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd(input logic [2:0] a, input logic b); step(a, 0, 1, b, 0, 0, 0, 0); endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d); step(a, 1, 0, 0, d, 0, 0, 0); endtask
  task automatic push(input logic [7:0] v); step(3'd0, 0, 0, 0, 0, 0, 1, v); endtask
  task automatic pop();           step(3'd0, 0, 0, 0, 0, 1, 0, 0); endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R13", {30'h0, irq, txHasData}, 32'h0);
    rstN = 1'b1;
    // reset state and layout
    rd(3'd1, 0); chk("R13", regRdata, 32'h0);
    rd(3'd1, 0); chk("R8", regRdata, 32'h0000_0100);
    rd(3'd0, 0); chk("R11", regRdata, 32'h0000_0403);
    rd(3'd2, 0); chk("R13", regRdata, 32'h0);
    // transmit byte order and empty pop
    wr(3'd3, 32'hA1B2_C3D4);
    for (int i = 0; i < 4; i++) pop();
    pop();
    rd(3'd1, 0); chk("R2", {26'h0, regRdata[21:16]}, 32'd0);
    // fill transmit, reject overflow write
    for (int i = 0; i < 8; i++) wr(3'd3, 32'h1000_0000 + i);
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd1, 0); chk("R3", {26'h0, regRdata[21:16]}, 32'd32);
    wr(3'd1, 32'h0000_0100);
    wr(3'd1, 32'h0);
    rd(3'd1, 0); chk("R9", {31'h0, regRdata[8]}, 32'd0);
    for (int i = 0; i < 32; i++) pop();
    idle();
    rd(3'd1, 0); chk("R8", {31'h0, regRdata[8]}, 32'd1);
    // receive threshold, mask, partial reads
    wr(3'd2, 32'h0000_0200);
    push(8'h11); push(8'h22); push(8'h33); idle();
    chk("R7", {31'h0, irq}, 32'd0);
    push(8'h44); idle();
    chk("R10", {31'h0, irq}, 32'd1);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 0); chk("R12", {26'h0, regRdata[29:24]}, 32'd4);
    chk("R7", {31'h0, regRdata[9]}, 32'd1);
    rd(3'd4, 1); chk("R5", regRdata, 32'h0000_0011);
    rd(3'd4, 0); chk("R4", regRdata, 32'h2233_4400);
    rd(3'd4, 0); chk("R4", regRdata, 32'h0);
    // receive overflow
    for (int i = 0; i < 33; i++) push(8'(i + 1));
    rd(3'd1, 0); chk("R6", {26'h0, regRdata[29:24]}, 32'd32);
    for (int i = 0; i < 8; i++) rd(3'd4, 0);
    rd(3'd1, 0); chk("R6", {26'h0, regRdata[29:24]}, 32'd0);
    // reprogrammed thresholds
    wr(3'd0, 32'h0000_2000);
    wr(3'd1, 32'h0000_0300);
    idle();
    rd(3'd1, 0); chk("R11", {30'h0, regRdata[9:8]}, 32'd0);
    push(8'h5A); idle();
    rd(3'd1, 0); chk("R11", {31'h0, regRdata[9]}, 32'd1);
    rd(3'd4, 1);
    wr(3'd0, 32'h0000_0403);
    // seeded random traffic
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      logic ep = ($urandom_range(0, 1) == 1);
      logic eh = ($urandom_range(0, 9) < 6);
      logic [7:0] eb = 8'($urandom);
      case (op)
        0, 1, 2: step(3'd3, 1, 0, 0, $urandom, ep, eh, eb);
        3:       step(3'd4, 0, 1, 0, 0, ep, eh, eb);
        4:       step(3'd4, 0, 1, 1, 0, ep, eh, eb);
        5:       step(3'd1, 0, 1, 0, 0, ep, eh, eb);
        6:       step(3'd1, 1, 0, 0, $urandom, ep, eh, eb);
        7:       step(3'd2, 1, 0, 0, $urandom, ep, eh, eb);
        8:       step(3'd0, 1, 0, 0, {16'h0, 8'($urandom_range(0, 40)), 8'($urandom_range(0, 40))}, ep, eh, eb);
        default: step(3'($urandom_range(0, 2)), 0, 1, 0, 0, ep, eh, eb);
      endcase
    end
    idle();
    finishRun();
  end
endmodule